// File: doc/BRIEF.md
# Strobed Handshake Data Port

This block is a single byte-wide parallel port that moves data between a CPU-side register interface and a peripheral under a two-wire handshake. The direction is chosen by a configuration input. As an input port, the peripheral pulses an active-low strobe. On the falling edge the port captures the data pins and raises an input-full flag, and a CPU read of the port empties it. As an output port, a CPU write fills the output latch and drives an active-low output-full pin. The peripheral then answers with an active-low acknowledge pulse, whose falling edge empties the buffer.

An interrupt request tells the CPU when it is time to act. In input direction that means data is waiting. In output direction it means the buffer is free. In both cases the request is held back while the handshake line is still low. The block also produces the three bits it places into the shared port C status word. The bit positions depend on whether the unit serves the first or the second port group, which is chosen by a parameter. The handshake line is asynchronous to the clock and passes through a synchronizer before any edge is detected.

Top module: `strobe_port`

## Requirements
- R1: In input direction (`cfg_dir_in`=1), a falling edge of the synchronized `hs_n` copies `pin_din` into the input latch and sets the full flag. While the flag is set, `flag_pin` is 1.
- R2: In input direction, `cpu_rdata` shows the input latch, and a `cpu_rd` pulse clears the full flag at the next clock. A strobe edge detected in the same cycle takes priority and sets the flag.
- R3: In input direction, `irq` is 1 exactly one clock after a cycle in which `cfg_irq_en`, the full flag and the synchronized `hs_n` level are all 1. Otherwise it is 0 one clock later.
- R4: In output direction (`cfg_dir_in`=0), a `cpu_wr` loads `cpu_wdata` into the output latch, which appears on `pin_dout` and `cpu_rdata`, and it sets the full flag. `flag_pin` is 0 while the flag is full and 1 otherwise. `pin_doe` is 1 only in output direction.
- R5: In output direction, a falling edge of the synchronized `hs_n` clears the full flag. A write in the same cycle takes priority and keeps the flag set.
- R6: In output direction, `irq` is 1 exactly one clock after a cycle in which `cfg_irq_en` is 1, the buffer is not full and the synchronized `hs_n` level is 1.
- R7: `hs_n` passes through SYNC_STAGES flops. With the default of 2, a change of `hs_n` set up before rising edge k takes effect on the full flag at edge k+2, and on `irq` one edge after its condition holds.
- R8: With GROUP_A=1, `stat_mask` in input direction is 0x38, with bit 5 = full, bit 4 = `cfg_irq_en` and bit 3 = `irq`. In output direction it is 0xC8, with bit 7 = inverted full (the pin level), bit 6 = `cfg_irq_en` and bit 3 = `irq`.
- R9: With GROUP_A=0, `stat_mask` is 0x07, with bit 2 = `cfg_irq_en`, bit 1 = `flag_pin` level and bit 0 = `irq`. In every configuration, bits of `stat_word` outside `stat_mask` are 0.
- R10: After reset, both latches are 0, the full flag is clear and `irq` is 0. Any change of `cfg_dir_in` clears the full flag at the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dir_in | input | 1 | 1 = input port, 0 = output port |
| cfg_irq_en | input | 1 | Interrupt enable |
| cpu_rd | input | 1 | One-clock CPU read of the port |
| cpu_wr | input | 1 | One-clock CPU write of the port |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | Input latch (input dir) or output latch (output dir) |
| pin_din | input | DATA_W | Peripheral data pins, sampled on strobe |
| pin_dout | output | DATA_W | Output latch toward the pins |
| pin_doe | output | 1 | Pin drive enable, 1 in output direction |
| hs_n | input | 1 | Asynchronous active-low strobe / acknowledge |
| flag_pin | output | 1 | Input-full (high active) or output-full (low active) pin |
| irq | output | 1 | Registered interrupt request |
| stat_word | output | 8 | Bits inserted into the port C status word |
| stat_mask | output | 8 | Which status bits this unit owns |

## Verification
The assertions assume that `cpu_rd` and `cpu_wr` are single-clock requests synchronous to `clk`, and that the configuration inputs change only between clock edges. The only input they treat as asynchronous is `hs_n`. The stimulus drives every input a short time after the rising edge. In the random phase it holds `hs_n` at each level for a random number of clocks, sometimes only one, so that strobe edges coincide with reads, writes and direction flips. The data pins may change at any time, because the model samples them at the same edge the design uses to capture them.

// File: rtl/strobe_port_pkg.sv
package strobe_port_pkg;

   typedef enum logic {
      DIR_OUT = 1'b0,
      DIR_IN  = 1'b1
   } port_dir_e;

   localparam int unsigned STAT_W = 8;

   // first group, receive side
   localparam int unsigned GA_RX_FULL = 5;
   localparam int unsigned GA_RX_EN   = 4;
   // first group, send side
   localparam int unsigned GA_TX_FULL = 7;
   localparam int unsigned GA_TX_EN   = 6;
   // first group, shared
   localparam int unsigned GA_IRQ     = 3;
   // second group
   localparam int unsigned GB_EN      = 2;
   localparam int unsigned GB_FULL    = 1;
   localparam int unsigned GB_IRQ     = 0;

endpackage

// File: rtl/strobe_port_sync.sv
module strobe_port_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_n,
   output logic level,
   output logic fall
);
   localparam int unsigned CHAIN_W = STAGES + 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("strobe_port_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[CHAIN_W-2:0], line_n};
   end

   assign level = chain_q[STAGES-1];
   assign fall  = chain_q[STAGES] & ~chain_q[STAGES-1];

   AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      fall |-> $past(level)) else $error("sync fall without prior high"); // R7

endmodule

// File: rtl/strobe_port_buf.sv
module strobe_port_buf #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_in,
   input  logic              dir_chg,
   input  logic              fall,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [DATA_W-1:0] pin_din,
   output logic [DATA_W-1:0] in_latch,
   output logic [DATA_W-1:0] out_latch,
   output logic              full
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("strobe_port_buf: DATA_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_latch  <= '0;
         out_latch <= '0;
         full      <= 1'b0;
      end else begin
         if (dir_in && fall)    in_latch  <= pin_din;
         if (!dir_in && cpu_wr) out_latch <= cpu_wdata;
         if (dir_chg) begin
            full <= 1'b0;
         end else if (dir_in) begin
            if (fall)        full <= 1'b1;
            else if (cpu_rd) full <= 1'b0;
         end else begin
            if (cpu_wr)      full <= 1'b1;
            else if (fall)   full <= 1'b0;
         end
      end
   end

   AST_RX_EDGE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_in && fall && !dir_chg) |=> (full && in_latch == $past(pin_din))) else $error("rx fill"); // R1
   AST_RX_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_in && cpu_rd && !fall && !dir_chg) |=> !full) else $error("rx read"); // R2
   AST_TX_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_in && cpu_wr && !dir_chg) |=> (full && out_latch == $past(cpu_wdata))) else $error("tx fill"); // R4
   AST_TX_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_in && fall && !cpu_wr && !dir_chg) |=> !full) else $error("tx ack"); // R5
   AST_DIR_FLIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      dir_chg |=> !full) else $error("dir flip"); // R10

endmodule

// File: rtl/strobe_port_irq.sv
module strobe_port_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_in,
   input  logic irq_en,
   input  logic full,
   input  logic line_high,
   output logic irq
);
   logic ready;

   // receive side wants a full buffer, send side an empty one
   assign ready = dir_in ? full : ~full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= irq_en & ready & line_high;
   end

   AST_IRQ_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(line_high)) else $error("irq while line low"); // R3
   AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(irq_en)) else $error("irq while disabled"); // R6

endmodule

// File: rtl/strobe_port_stat.sv
module strobe_port_stat
   import strobe_port_pkg::*;
#(
   parameter bit GROUP_A = 1'b1
) (
   input  logic              dir_in,
   input  logic              irq_en,
   input  logic              full,
   input  logic              irq,
   output logic [STAT_W-1:0] word,
   output logic [STAT_W-1:0] mask
);
   generate
      if (GROUP_A) begin : g_first
         always_comb begin
            word = '0;
            mask = '0;
            mask[GA_IRQ] = 1'b1;
            word[GA_IRQ] = irq;
            if (dir_in) begin
               mask[GA_RX_FULL] = 1'b1;
               mask[GA_RX_EN]   = 1'b1;
               word[GA_RX_FULL] = full;
               word[GA_RX_EN]   = irq_en;
            end else begin
               mask[GA_TX_FULL] = 1'b1;
               mask[GA_TX_EN]   = 1'b1;
               word[GA_TX_FULL] = ~full;
               word[GA_TX_EN]   = irq_en;
            end
         end
      end else begin : g_second
         always_comb begin
            word = '0;
            mask = '0;
            mask[GB_EN]   = 1'b1;
            mask[GB_FULL] = 1'b1;
            mask[GB_IRQ]  = 1'b1;
            word[GB_EN]   = irq_en;
            word[GB_FULL] = dir_in ? full : ~full;
            word[GB_IRQ]  = irq;
         end
      end
   endgenerate

endmodule

// File: rtl/strobe_port.sv
module strobe_port
   import strobe_port_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          GROUP_A     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_dir_in,
   input  logic              cfg_irq_en,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic [DATA_W-1:0] pin_din,
   output logic [DATA_W-1:0] pin_dout,
   output logic              pin_doe,
   input  logic              hs_n,
   output logic              flag_pin,
   output logic              irq,
   output logic [STAT_W-1:0] stat_word,
   output logic [STAT_W-1:0] stat_mask
);
   logic              hs_level;
   logic              hs_fall;
   logic              dir_q;
   logic              dir_chg;
   logic              full;
   logic [DATA_W-1:0] in_latch;
   logic [DATA_W-1:0] out_latch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dir_q <= DIR_IN;
      else        dir_q <= cfg_dir_in;
   end
   assign dir_chg = dir_q ^ cfg_dir_in;

   strobe_port_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_n (hs_n),
      .level  (hs_level),
      .fall   (hs_fall)
   );

   strobe_port_buf #(.DATA_W(DATA_W)) i_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .dir_in    (cfg_dir_in),
      .dir_chg   (dir_chg),
      .fall      (hs_fall),
      .cpu_rd    (cpu_rd),
      .cpu_wr    (cpu_wr),
      .cpu_wdata (cpu_wdata),
      .pin_din   (pin_din),
      .in_latch  (in_latch),
      .out_latch (out_latch),
      .full      (full)
   );

   strobe_port_irq i_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .dir_in    (cfg_dir_in),
      .irq_en    (cfg_irq_en),
      .full      (full),
      .line_high (hs_level),
      .irq       (irq)
   );

   strobe_port_stat #(.GROUP_A(GROUP_A)) i_stat (
      .dir_in (cfg_dir_in),
      .irq_en (cfg_irq_en),
      .full   (full),
      .irq    (irq),
      .word   (stat_word),
      .mask   (stat_mask)
   );

   assign cpu_rdata = cfg_dir_in ? in_latch : out_latch;
   assign pin_dout  = out_latch;
   assign pin_doe   = ~cfg_dir_in;
   assign flag_pin  = cfg_dir_in ? full : ~full;

   AST_STAT_THREE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(stat_mask) == 3) && ((stat_word & ~stat_mask) == '0)) else $error("status fields"); // R9
   AST_STAT_IRQ_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_word[GROUP_A ? GA_IRQ : GB_IRQ] == irq)) else $error("status irq bit"); // R8
   AST_FLAG_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_dir_in && cpu_wr && !dir_chg) |=> (!flag_pin || cfg_dir_in)) else $error("tx flag"); // R4

endmodule

// File: tb/test_strobe_port.sv
module test_strobe_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_dir_in = 1'b1;
   logic       cfg_irq_en = 1'b0;
   logic       cpu_rd = 1'b0;
   logic       cpu_wr = 1'b0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] pin_din = '0;
   logic       hs_n = 1'b1;

   logic [7:0] a_rdata, a_dout, a_sw, a_sm;
   logic       a_doe, a_flag, a_irq;
   logic [7:0] b_rdata, b_dout, b_sw, b_sm;
   logic       b_doe, b_flag, b_irq;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   strobe_port #(.GROUP_A(1'b1)) i_strobe_port (
      .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in), .cfg_irq_en(cfg_irq_en),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(a_rdata),
      .pin_din(pin_din), .pin_dout(a_dout), .pin_doe(a_doe), .hs_n(hs_n),
      .flag_pin(a_flag), .irq(a_irq), .stat_word(a_sw), .stat_mask(a_sm));

   strobe_port #(.GROUP_A(1'b0)) i_strobe_port_b (
      .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in), .cfg_irq_en(cfg_irq_en),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(b_rdata),
      .pin_din(pin_din), .pin_dout(b_dout), .pin_doe(b_doe), .hs_n(hs_n),
      .flag_pin(b_flag), .irq(b_irq), .stat_word(b_sw), .stat_mask(b_sm));

   // behavioural reference, advanced on every rising edge
   bit       m_hist [$] = '{1'b1, 1'b1, 1'b1};
   bit       m_full = 0, m_dir = 1, m_irq = 0;
   bit [7:0] m_in = 0, m_out = 0;

   always @(posedge clk) begin
      bit lvl, edge_seen, chg;
      lvl       = m_hist[1];
      edge_seen = m_hist[2] && !m_hist[1];
      chg       = (m_dir != cfg_dir_in);
      if (!rst_n) begin
         m_hist = '{1'b1, 1'b1, 1'b1};
         m_full = 0; m_dir = 1; m_irq = 0; m_in = 0; m_out = 0;
      end else begin
         m_irq = cfg_irq_en && lvl && (cfg_dir_in ? m_full : !m_full);
         if (cfg_dir_in && edge_seen) m_in = pin_din;
         if (!cfg_dir_in && cpu_wr) m_out = cpu_wdata;
         if (chg) m_full = 0;
         else if (cfg_dir_in) begin
            if (edge_seen) m_full = 1;
            else if (cpu_rd) m_full = 0;
         end else begin
            if (cpu_wr) m_full = 1;
            else if (edge_seen) m_full = 0;
         end
         m_hist.push_front(hs_n);
         void'(m_hist.pop_back());
         m_dir = cfg_dir_in;
      end
   end

   task automatic cmp(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %02h expected %02h", req, $time, act, exp);
      end
   endtask

   function automatic bit [7:0] exp_stat_a();
      bit [7:0] w = 0;
      w[3] = m_irq;
      if (cfg_dir_in) begin w[5] = m_full; w[4] = cfg_irq_en; end
      else            begin w[7] = !m_full; w[6] = cfg_irq_en; end
      return w;
   endfunction

   function automatic bit [7:0] exp_stat_b();
      return {5'b0, cfg_irq_en, (cfg_dir_in ? m_full : !m_full), m_irq};
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         bit fl;
         fl = cfg_dir_in ? m_full : !m_full;
         cmp("R1/R4 flag_pin", {7'b0, a_flag}, {7'b0, fl});
         cmp("R2/R4 cpu_rdata", a_rdata, cfg_dir_in ? m_in : m_out);
         cmp("R4 pin_dout", a_dout, m_out);
         cmp("R4 pin_doe", {7'b0, a_doe}, {7'b0, !cfg_dir_in});
         cmp("R3/R6 irq", {7'b0, a_irq}, {7'b0, m_irq});
         cmp("R8 stat_mask", a_sm, cfg_dir_in ? 8'h38 : 8'hC8);
         cmp("R8 stat_word", a_sw, exp_stat_a());
         cmp("R9 stat_mask", b_sm, 8'h07);
         cmp("R9 stat_word", b_sw, exp_stat_b());
         cmp("R7 group B irq", {7'b0, b_irq}, {7'b0, m_irq});
      end
   end

   task automatic tick(int n = 1);
      repeat (n) begin
         @(posedge clk);
         #2;
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick();
      cmp("R10 reset flag", {7'b0, a_flag}, 8'h00);
      cmp("R10 reset irq", {7'b0, a_irq}, 8'h00);
      cmp("R10 reset rdata", a_rdata, 8'h00);

      // input direction capture
      cfg_irq_en = 1'b1;
      pin_din = 8'hA5;
      hs_n = 1'b0;
      tick(2);
      cmp("R7 flag not yet set", {7'b0, a_flag}, 8'h00);
      tick();
      cmp("R1 flag set", {7'b0, a_flag}, 8'h01);
      cmp("R1 captured data", a_rdata, 8'hA5);
      tick();
      cmp("R3 irq held while strobe low", {7'b0, a_irq}, 8'h00);
      hs_n = 1'b1;
      tick(3);
      cmp("R3 irq after strobe high", {7'b0, a_irq}, 8'h01);
      cpu_rd = 1'b1;
      tick();
      cpu_rd = 1'b0;
      cmp("R2 read empties", {7'b0, a_flag}, 8'h00);
      tick();
      cmp("R3 irq drops", {7'b0, a_irq}, 8'h00);

      // output direction
      cfg_dir_in = 1'b0;
      tick(2);
      cmp("R6 irq when empty", {7'b0, a_irq}, 8'h01);
      cpu_wr = 1'b1;
      cpu_wdata = 8'h96;
      tick();
      cpu_wr = 1'b0;
      cmp("R4 flag low when full", {7'b0, a_flag}, 8'h00);
      cmp("R4 pin_dout", a_dout, 8'h96);
      tick();
      cmp("R6 irq drops when full", {7'b0, a_irq}, 8'h00);
      hs_n = 1'b0;
      tick(3);
      cmp("R5 ack empties", {7'b0, a_flag}, 8'h01);
      hs_n = 1'b1;
      tick(3);
      cmp("R6 irq after ack high", {7'b0, a_irq}, 8'h01);
      cmp("R8 status group A", a_sw, 8'hC8);
      cmp("R9 status group B", b_sw, 8'h07);

      // direction flip while full
      cpu_wr = 1'b1;
      cpu_wdata = 8'h3C;
      tick();
      cpu_wr = 1'b0;
      cfg_dir_in = 1'b1;
      tick();
      cmp("R10 flip clears full", {7'b0, a_flag}, 8'h00);

      // random traffic, compared every clock by the model
      for (int i = 0; i < 400; i++) begin
         int hold;
         hold = 1 + int'($urandom_range(0, 5));
         hs_n = ~hs_n;
         for (int k = 0; k < hold; k++) begin
            cpu_rd     = ($urandom_range(0, 5) == 0);
            cpu_wr     = ($urandom_range(0, 5) == 0);
            cpu_wdata  = 8'($urandom);
            pin_din    = 8'($urandom);
            if ($urandom_range(0, 40) == 0) cfg_dir_in = ~cfg_dir_in;
            if ($urandom_range(0, 20) == 0) cfg_irq_en = ~cfg_irq_en;
            tick();
         end
      end
      cpu_rd = 1'b0;
      cpu_wr = 1'b0;
      tick(4);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule